// File: doc/BRIEF.md
# Fixed-Target Virtual Channel Arbiter

This block is the virtual channel allocation stage of a router in which the routing stage has already fixed, per flow, which output port and which downstream virtual channel a packet will use. Each input virtual channel that holds a routed head flit presents a request naming one output port and one output VC. Because the target is fixed, allocation becomes plain arbitration. Every output VC has its own round-robin arbiter that picks one of the P·V input VCs asking for it. The allocator never picks among output VCs.

A grant is visible in the same cycle as the request. From the next clock edge the output VC is owned by the winner. It stays owned until the tail flit of that packet leaves, which is signalled by a one-cycle release pulse on that output VC. An input VC that owns an output VC cannot win a second one. Requests that name a port or VC outside the configured range are ignored. The winner then goes on to switch allocation, which lies outside this block, as do credits and the crossbar.

Top module: `vc_static_alloc`

## Requirements
- R1: After reset no output VC is owned, no grant is issued, and every arbiter's search starts at requester index 0.
- R2: A valid request to a free output VC with no competitor is granted combinationally in the same cycle it is presented.
- R3: Requester i with port p and VC v targets output VC index p·V + v. Requester i's fields sit at bits [i·PW +: PW] of `req_port` and [i·VW +: VW] of `req_vc`, and its grant is bit i of `in_grant`. After a grant, bit p·V + v of `ovc_busy` is set on the next edge.
- R4: At most one requester is granted a given output VC in a cycle, and no requester receives more than one grant.
- R5: An owned output VC issues no grant. A granted output VC reads busy from the next edge.
- R6: A release pulse on an owned output VC frees it at the next edge. A release on a free output VC has no effect. Without a release an owned VC stays owned.
- R7: Round-robin order: after requester w wins an output VC, that VC's next search starts at index (w+1) mod P·V. The search position moves only when a grant is made.
- R8: An input VC that currently owns an output VC is not granted another one until its own output VC is released.
- R9: A request whose port index is P or more, or whose VC index is V or more, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N (=P·V) | Per input VC: a routed head flit is requesting |
| req_port | input | N·PW | Per input VC: requested output port |
| req_vc | input | N·VW | Per input VC: requested downstream VC (fixed by routing) |
| tail_release | input | N | Per output VC: tail flit of the owner departed this cycle |
| in_grant | output | N | Per input VC: won its requested output VC this cycle |
| ovc_busy | output | N | Per output VC: currently owned |

## Verification
A corrupted owner record shows up in `ovc_busy` at the next edge. It can also show up as a grant on an owned VC, or as a missing grant on a freed VC, in the first cycle after the error in which that VC is requested. A wrong round-robin pointer stays hidden until two or more requesters contend for the same output VC, and only then changes the winner. The reference model therefore compares the full grant and busy vectors every cycle. Directed contention sequences make a pointer error show at the first re-arbitration.

// File: rtl/vca_pkg.sv
package vca_pkg;

  // Flat output VC index for a (port, vc) pair.
  function automatic int target_of(int port, int vc, int nvc);
    return port * nvc + vc;
  endfunction

  // Next round-robin start position after a winner.
  function automatic int rr_after(int winner, int n);
    return (winner + 1 == n) ? 0 : winner + 1;
  endfunction

  // Width for an index over n items, never zero.
  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/vca_req_decode.sv
module vca_req_decode
  import vca_pkg::*;
#(
  parameter int P  = 5,
  parameter int V  = 2,
  parameter int N  = P * V,
  parameter int PW = idx_width(P),
  parameter int VW = idx_width(V)
) (
  input  logic [N-1:0]    req_valid,
  input  logic [N*PW-1:0] req_port,
  input  logic [N*VW-1:0] req_vc,
  input  logic [N-1:0]    in_held,
  output logic [N*N-1:0]  req_mat     // [o*N + i]: input i requests output VC o
);

  for (genvar i = 0; i < N; i++) begin : g_in
    logic [PW-1:0] port_i;
    logic [VW-1:0] vc_i;
    logic          live_i;
    int            tgt_i;

    assign port_i = req_port[i*PW +: PW];
    assign vc_i   = req_vc[i*VW +: VW];
    assign live_i = req_valid[i] && !in_held[i]
                    && (int'(port_i) < P) && (int'(vc_i) < V);
    assign tgt_i  = target_of(int'(port_i), int'(vc_i), V);

    for (genvar o = 0; o < N; o++) begin : g_out
      assign req_mat[o*N + i] = live_i && (tgt_i == o);
    end
  end

endmodule

// File: rtl/vca_rr_arb.sv
module vca_rr_arb
  import vca_pkg::*;
#(
  parameter int N  = 10,
  parameter int IW = idx_width(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         blocked,
  output logic [N-1:0] gnt
);

  logic [IW-1:0] ptr;
  logic [IW-1:0] win;
  logic          found;

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < N; k++) begin
      if (!found && req[(int'(ptr) + k) % N]) begin
        found = 1'b1;
        win   = IW'((int'(ptr) + k) % N);
      end
    end
    gnt = '0;
    if (found && !blocked) gnt[win] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (found && !blocked) begin
      ptr <= IW'(rr_after(int'(win), N));
    end
  end

endmodule

// File: rtl/vca_owner_track.sv
module vca_owner_track #(
  parameter int N = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*N-1:0] ovc_gnt,       // [o*N + i]
  input  logic [N-1:0]   tail_release,
  output logic [N-1:0]   ovc_busy,
  output logic [N-1:0]   in_held
);

  logic [N*N-1:0] own;  // [o*N + i]: input i owns output VC o

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own <= '0;
    end else begin
      for (int o = 0; o < N; o++) begin
        if (ovc_busy[o] && tail_release[o]) begin
          own[o*N +: N] <= '0;
        end else if (|ovc_gnt[o*N +: N]) begin
          own[o*N +: N] <= ovc_gnt[o*N +: N];
        end
      end
    end
  end

  always_comb begin
    in_held = '0;
    for (int o = 0; o < N; o++) begin
      ovc_busy[o] = |own[o*N +: N];
      in_held     = in_held | own[o*N +: N];
    end
  end

endmodule

// File: rtl/vc_static_alloc.sv
module vc_static_alloc
  import vca_pkg::*;
#(
  parameter int P  = 5,
  parameter int V  = 2,
  parameter int N  = P * V,
  parameter int PW = idx_width(P),
  parameter int VW = idx_width(V)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_valid,
  input  logic [N*PW-1:0] req_port,
  input  logic [N*VW-1:0] req_vc,
  input  logic [N-1:0]    tail_release,
  output logic [N-1:0]    in_grant,
  output logic [N-1:0]    ovc_busy
);

  // Named internal events, visible to the bound checker.
  logic [N*N-1:0] req_mat;
  logic [N*N-1:0] ovc_gnt;
  logic [N-1:0]   in_held;

  vca_req_decode #(.P(P), .V(V), .N(N), .PW(PW), .VW(VW)) u_dec (
    .req_valid (req_valid),
    .req_port  (req_port),
    .req_vc    (req_vc),
    .in_held   (in_held),
    .req_mat   (req_mat)
  );

  for (genvar o = 0; o < N; o++) begin : g_arb
    vca_rr_arb #(.N(N)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_mat[o*N +: N]),
      .blocked (ovc_busy[o]),
      .gnt     (ovc_gnt[o*N +: N])
    );
  end

  vca_owner_track #(.N(N)) u_own (
    .clk          (clk),
    .rst_n        (rst_n),
    .ovc_gnt      (ovc_gnt),
    .tail_release (tail_release),
    .ovc_busy     (ovc_busy),
    .in_held      (in_held)
  );

  always_comb begin
    in_grant = '0;
    for (int o = 0; o < N; o++) begin
      in_grant = in_grant | ovc_gnt[o*N +: N];
    end
  end

endmodule

// File: rtl/vca_checker.sv
module vca_checker #(
  parameter int N = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N*N-1:0] ovc_gnt,
  input logic [N-1:0]   ovc_busy,
  input logic [N-1:0]   tail_release,
  input logic [N-1:0]   in_held,
  input logic [N-1:0]   in_grant
);

  for (genvar o = 0; o < N; o++) begin : g_o
    assert_ovc_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ovc_gnt[o*N +: N]));

    assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ovc_busy[o] |-> (ovc_gnt[o*N +: N] == '0));

    assert_grant_sets_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|ovc_gnt[o*N +: N]) |=> ovc_busy[o]);

    assert_release_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovc_busy[o] && tail_release[o]) |=> !ovc_busy[o]);

    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovc_busy[o] && !tail_release[o]) |=> ovc_busy[o]);

    assert_idle_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovc_busy[o] && (ovc_gnt[o*N +: N] == '0)) |=> !ovc_busy[o]);
  end

  for (genvar i = 0; i < N; i++) begin : g_i
    logic [N-1:0] col;
    always_comb begin
      for (int o = 0; o < N; o++) col[o] = ovc_gnt[o*N + i];
    end

    assert_input_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));

    assert_owner_no_regrant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_held[i] |-> !in_grant[i]);
  end

endmodule

bind vc_static_alloc vca_checker #(.N(N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ovc_gnt      (ovc_gnt),
  .ovc_busy     (ovc_busy),
  .tail_release (tail_release),
  .in_held      (in_held),
  .in_grant     (in_grant)
);

// File: tb/tb_vc_static_alloc.sv
module tb_vc_static_alloc;
  localparam int P  = 5;
  localparam int V  = 2;
  localparam int N  = P * V;
  localparam int PW = 3;
  localparam int VW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]    req_valid, tail_release, in_grant, ovc_busy;
  logic [N*PW-1:0] req_port;
  logic [N*VW-1:0] req_vc;

  vc_static_alloc #(.P(P), .V(V)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .req_vc(req_vc), .tail_release(tail_release),
    .in_grant(in_grant), .ovc_busy(ovc_busy)
  );

  // Stimulus state and behavioural reference model.
  int r_valid[N], r_port[N], r_vc[N], rel[N];
  int m_own[N];   // owner of output VC, -1 when free
  int m_ptr[N];   // search start per output VC
  int exp_g[N];   // output VC won by input i this cycle, -1 if none
  logic [N-1:0] last_grant;
  int errors = 0, checks = 0;
  bit done = 0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic bit owns_any(int i);
    for (int o = 0; o < N; o++) if (m_own[o] == i) return 1;
    return 0;
  endfunction

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      req_valid[i]         = (r_valid[i] != 0);
      req_port[i*PW +: PW] = PW'(r_port[i]);
      req_vc[i*VW +: VW]   = VW'(r_vc[i]);
      tail_release[i]      = (rel[i] != 0);
    end
  endtask

  task automatic compute_expect();
    for (int i = 0; i < N; i++) exp_g[i] = -1;
    for (int o = 0; o < N; o++) begin
      if (m_own[o] < 0) begin
        for (int k = 0; k < N; k++) begin
          int i;
          i = (m_ptr[o] + k) % N;
          if (r_valid[i] != 0 && !owns_any(i) && r_port[i] < P && r_vc[i] < V
              && r_port[i] * V + r_vc[i] == o) begin
            exp_g[i] = o;
            break;
          end
        end
      end
    end
  endtask

  task automatic step(string tag);
    logic [N-1:0] eg, eb;
    drive();
    #1;
    compute_expect();
    for (int i = 0; i < N; i++) eg[i] = (exp_g[i] >= 0);
    for (int o = 0; o < N; o++) eb[o] = (m_own[o] >= 0);
    last_grant = in_grant;
    check(in_grant == eg, tag, "grant vector", 64'(in_grant), 64'(eg));
    check(ovc_busy == eb, tag, "busy vector", 64'(ovc_busy), 64'(eb));
    @(posedge clk);
    for (int o = 0; o < N; o++) if (m_own[o] >= 0 && rel[o] != 0) m_own[o] = -1;
    for (int i = 0; i < N; i++) begin
      if (exp_g[i] >= 0) begin
        m_own[exp_g[i]] = i;
        m_ptr[exp_g[i]] = (i + 1) % N;
        r_valid[i] = 0;
      end
    end
    for (int o = 0; o < N; o++) rel[o] = 0;
    @(negedge clk);
  endtask

  task automatic ask(int i, int port, int vc);
    r_valid[i] = 1; r_port[i] = port; r_vc[i] = vc;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      r_valid[i] = 0; r_port[i] = 0; r_vc[i] = 0; rel[i] = 0;
      m_own[i] = -1; m_ptr[i] = 0;
    end
    drive();
    repeat (3) @(negedge clk);
    check(ovc_busy == '0 && in_grant == '0, "R1", "reset state",
          64'({in_grant, ovc_busy}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3: lone request, port 2 VC 1 -> output VC 5
    ask(3, 2, 1);
    step("R2 R3");
    check(last_grant == N'(1 << 3), "R2", "same-cycle grant", 64'(last_grant), 64'(1 << 3));
    check(ovc_busy == N'(1 << 5), "R3", "target index", 64'(ovc_busy), 64'(1 << 5));

    // R7 R5: three contenders for output VC 0
    ask(0, 0, 0); ask(4, 0, 0); ask(7, 0, 0);
    step("R1 R7");
    check(last_grant == N'(1 << 0), "R1", "first winner from index 0", 64'(last_grant), 64'(1));
    repeat (3) step("R5");
    check(last_grant == '0, "R5", "busy VC grants nothing", 64'(last_grant), 64'(0));
    rel[0] = 1; step("R6 R5");
    step("R7");
    check(last_grant == N'(1 << 4), "R7", "rotation after 0", 64'(last_grant), 64'(1 << 4));
    rel[0] = 1; step("R6");
    step("R7");
    check(last_grant == N'(1 << 7), "R7", "rotation after 4", 64'(last_grant), 64'(1 << 7));
    rel[0] = 1; step("R6");
    ask(0, 0, 0); ask(1, 0, 0);
    step("R7");
    check(last_grant == N'(1 << 0), "R7", "wraparound from 8", 64'(last_grant), 64'(1));

    // R6: release on a free output VC
    rel[9] = 1; step("R6");
    check(ovc_busy == N'((1 << 0) | (1 << 5)), "R6", "idle release no effect",
          64'(ovc_busy), 64'((1 << 0) | (1 << 5)));

    // R9: out-of-range port
    ask(2, 6, 0);
    repeat (3) step("R9");
    check(last_grant[2] == 1'b0 && ovc_busy == N'((1 << 0) | (1 << 5)), "R9",
          "bad port ignored", 64'({last_grant, ovc_busy}), 64'((1 << 0) | (1 << 5)));
    r_valid[2] = 0;

    // R8: owner of VC 5 asks for VC 2
    ask(3, 1, 0);
    step("R8");
    check(last_grant[3] == 1'b0, "R8", "owner not regranted", 64'(last_grant), 64'(0));
    rel[5] = 1; step("R8");
    step("R8");
    check(last_grant == N'(1 << 3), "R8", "granted after own release", 64'(last_grant), 64'(1 << 3));

    // R4: simultaneous contention on several VCs
    ask(5, 3, 1); ask(6, 3, 1); ask(8, 4, 0); ask(9, 4, 0); ask(2, 1, 1);
    step("R4");
    check($countones(last_grant) == 3, "R4", "one winner per VC",
          64'($countones(last_grant)), 64'(3));

    // Random traffic against the model
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < N; i++) begin
        if (r_valid[i] == 0 && !owns_any(i) && ($urandom % 3) == 0)
          ask(i, int'($urandom % 8), int'($urandom % 2));
        else if (r_valid[i] != 0 && r_port[i] >= P && ($urandom % 4) == 0)
          r_valid[i] = 0;
      end
      for (int o = 0; o < N; o++) begin
        if (m_own[o] >= 0) rel[o] = (($urandom % 4) == 0) ? 1 : 0;
        else rel[o] = (($urandom % 20) == 0) ? 1 : 0;
      end
      step("R2 R4 R5 R6 R7 R8 R9");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule